// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a byte-wide, register-mapped controller for a standard printer port. A host reaches it over a simple synchronous bus with a 3-bit address, one-cycle write and read strobes, and separate 8-bit write and read data. Inside are an output data latch, an input latch for reverse-direction reads, a control register and a status word whose busy and acknowledge flags form a small handshake state machine.

Software sends a byte by writing it to the data offset and then raising the strobe bit in the control register. That strobe transition emits the latched byte on `out_byte` with a one-clock `out_valid` pulse and marks the printer busy. Later status reads step the busy and acknowledge flags back to ready. If the strobe bit is written low while interrupts were enabled, an interrupt becomes pending. `irq` shows it as a level until the next status read.

The handshake machine has three states. **HS_READY** reports busy-complement=1 and ack=1. **HS_HELD** reports busy-complement=0 and ack=1. **HS_ACKLOW** reports busy-complement=0 and ack=0. The transitions are:
- *go_busy*: HS_READY to HS_HELD, on a strobe-high control write.
- *ack_drop*: HS_HELD to HS_ACKLOW, on a status read with control strobe low.
- *ack_return*: HS_ACKLOW to HS_READY, on a status read with control strobe low.
- *init_reset*: any state to HS_READY, on a control write with initialize at 0.

Top module: `prn_port_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC, status reads 0xD9, a data read returns 0xFF, and `irq` and `out_valid` are 0.
- R2: Offset 0 is data, 1 is status and 2 is control. Reads of offsets 3 to 7 return 0xFF, and writes to offsets 1 and 3 to 7 change no state.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns that value. Bit 5 is direction, bit 4 interrupt enable, bit 3 select, bit 2 initialize, bit 0 strobe.
- R4: A control write with bit 2 = 0 sets status to 0xD8: busy-complement (bit 7), ack (bit 6), online (bit 4) and error-complement (bit 3) set, paper-out (bit 5) and timeout (bit 0) clear.
- R5: A control write with bits 2, 3 and 0 all 1 clears status bit 7. If the previous control bit 0 was 0, it also drives `out_byte` with the output latch value for exactly one clock with `out_valid` high. Otherwise nothing is emitted.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets `irq` high if the previous control value had bit 4 set. Otherwise `irq` is unchanged.
- R7: A status read returns the status before the read and drives `irq` low afterwards.
- R8: When status bit 7 is 0 and control bit 0 is 0, a status read steps the flags once. If ack was 1 it is cleared. If ack was 0, ack and bit 7 are both set. In any other case the flags are unchanged.
- R9: A data read returns the input latch when control bit 5 is 1, and the output latch otherwise. The input latch loads `rev_data` in any cycle with `rev_load` high.
- R10: `bus_rdata` is registered. It shows the value of a read one clock after the cycle `bus_rd` is high, holds between reads, and each read cycle applies its side effects exactly once.
- R11: When `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored, with no side effects and no change to `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rev_load | input | 1 | Load enable for the reverse input latch |
| rev_data | input | 8 | Byte captured into the input latch |
| irq | output | 1 | Level interrupt, high while pending |
| out_byte | output | 8 | Emitted printer byte |
| out_valid | output | 1 | One-clock pulse qualifying out_byte |

## Verification
The embedded properties watch a fixed set of rules on every cycle:
- `out_valid` never lasts longer than one clock.
- Every emission follows a strobe-high control write, and every rising interrupt follows a strobe-low control write.
- Status reads clear the interrupt.
- Bad offsets read 0xFF.
- Forced control bits are present.
- Initialize writes and strobe-low status reads move the handshake machine as specified.
- A combined read and write leaves the interrupt level unchanged.

Only the bench scenarios can show the rest:
- The complete read-back values.
- The full handshake step order seen through successive status reads.
- Which latch a data read returns.
- Agreement with an arithmetic model over a long pseudo-random stream of mixed accesses.

// File: rtl/prn_pkg.sv
package prn_pkg;

    localparam int ADDR_DATA = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CTRL = 2;

    localparam int CB_STROBE = 0;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_IEN    = 4;
    localparam int CB_DIR    = 5;

    localparam logic [7:0] CTRL_FORCE = 8'hC0;
    localparam logic [7:0] CTRL_RESET = 8'hCC;
    localparam logic [7:0] BYTE_ONES  = 8'hFF;

    typedef enum logic [1:0] {
        HS_READY  = 2'd0,
        HS_HELD   = 2'd1,
        HS_ACKLOW = 2'd2
    } hs_state_t;

endpackage

// File: rtl/prn_hs_fsm.sv
module prn_hs_fsm
    import prn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_init,
    input  logic ev_busy,
    input  logic ev_step,
    output logic busy_n,
    output logic ack
);

    hs_state_t state_q;
    hs_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_READY: begin
                if (ev_busy) state_d = HS_HELD;
            end
            HS_HELD: begin
                if (ev_init)      state_d = HS_READY;
                else if (ev_step) state_d = HS_ACKLOW;
            end
            HS_ACKLOW: begin
                if (ev_init || ev_step) state_d = HS_READY;
            end
            default: state_d = HS_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_n = 1'b1;
        ack    = 1'b1;
        unique case (state_q)
            HS_READY:  begin busy_n = 1'b1; ack = 1'b1; end
            HS_HELD:   begin busy_n = 1'b0; ack = 1'b1; end
            HS_ACKLOW: begin busy_n = 1'b0; ack = 1'b0; end
            default:   begin busy_n = 1'b1; ack = 1'b1; end
        endcase
    end

    AST_HS_INIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_init |=> (busy_n && ack)); // R4
    AST_HS_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && ack && ev_step && !ev_init) |=> (!busy_n && !ack)); // R8
    AST_HS_ACK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !ack && ev_step && !ev_init) |=> (busy_n && ack)); // R8

endmodule

// File: rtl/prn_irq_flag.sv
module prn_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pending
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pending <= 1'b0;
        else if (clr_req) pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
    end

    AST_IRQ_SET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> pending); // R6

endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
    import prn_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          rev_load,
    input  logic [7:0]    rev_data,
    output logic          irq,
    output logic [7:0]    out_byte,
    output logic          out_valid
);

    logic [7:0] data_q;
    logic [7:0] rin_q;
    logic [7:0] ctrl_q;
    logic       tmo_q;
    logic [7:0] rdata_q;
    logic [7:0] obyte_q;
    logic       ovalid_q;

    logic       rd_go;
    logic       ctrl_wr;
    logic       data_wr;
    logic       stat_rd;
    logic [7:0] ctrl_new;
    logic       sel_path;
    logic       ev_init;
    logic       ev_busy;
    logic       ev_step;
    logic       emit;
    logic       irq_set;
    logic       busy_n;
    logic       ack;
    logic [7:0] status_w;
    logic [7:0] rd_mux;

    assign rd_go    = bus_rd && !bus_wr;
    assign ctrl_wr  = bus_wr && (bus_addr == AW'(ADDR_CTRL));
    assign data_wr  = bus_wr && (bus_addr == AW'(ADDR_DATA));
    assign stat_rd  = rd_go  && (bus_addr == AW'(ADDR_STAT));
    assign ctrl_new = bus_wdata | CTRL_FORCE;

    assign ev_init  = ctrl_wr && !ctrl_new[CB_INIT];
    assign sel_path = ctrl_wr && ctrl_new[CB_INIT] && ctrl_new[CB_SELECT];
    assign ev_busy  = sel_path && ctrl_new[CB_STROBE];
    assign emit     = ev_busy && !ctrl_q[CB_STROBE];
    assign irq_set  = sel_path && !ctrl_new[CB_STROBE] && ctrl_q[CB_IEN];
    assign ev_step  = stat_rd && !ctrl_q[CB_STROBE];

    prn_hs_fsm u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_init (ev_init),
        .ev_busy (ev_busy),
        .ev_step (ev_step),
        .busy_n  (busy_n),
        .ack     (ack)
    );

    prn_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (irq_set),
        .clr_req (stat_rd),
        .pending (irq)
    );

    assign status_w = {busy_n, ack, 1'b0, 1'b1, 1'b1, 2'b00, tmo_q};

    always_comb begin
        rd_mux = BYTE_ONES;
        if (bus_addr == AW'(ADDR_DATA))      rd_mux = ctrl_q[CB_DIR] ? rin_q : data_q;
        else if (bus_addr == AW'(ADDR_STAT)) rd_mux = status_w;
        else if (bus_addr == AW'(ADDR_CTRL)) rd_mux = ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= BYTE_ONES;
            rin_q    <= BYTE_ONES;
            ctrl_q   <= CTRL_RESET;
            tmo_q    <= 1'b1;
            rdata_q  <= BYTE_ONES;
            obyte_q  <= BYTE_ONES;
            ovalid_q <= 1'b0;
        end else begin
            if (data_wr)  data_q <= bus_wdata;
            if (rev_load) rin_q  <= rev_data;
            if (ctrl_wr)  ctrl_q <= ctrl_new;
            if (ev_init)  tmo_q  <= 1'b0;
            if (rd_go)    rdata_q <= rd_mux;
            ovalid_q <= emit;
            if (emit)     obyte_q <= data_q;
        end
    end

    assign bus_rdata = rdata_q;
    assign out_byte  = obyte_q;
    assign out_valid = ovalid_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5
    AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bus_wr && bus_addr == AW'(ADDR_CTRL) && bus_wdata[0]
                            && bus_wdata[2] && bus_wdata[3])); // R5
    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q == ($past(bus_wdata) | 8'hC0))); // R3
    AST_RD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == AW'(ADDR_STAT)) |=> !irq); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_wr && bus_addr == AW'(ADDR_CTRL) && !bus_wdata[0])); // R6
    AST_BAD_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr > AW'(ADDR_CTRL)) |=> (bus_rdata == 8'hFF)); // R2
    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd && bus_addr == AW'(ADDR_STAT)) |=> ($stable(irq) && $stable(bus_rdata))); // R11

endmodule

// File: tb/prn_port_ctrl_bench.sv
module prn_port_ctrl_bench;

    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rev_load = 1'b0;
    logic [7:0] rev_data = '0;
    logic       irq;
    logic [7:0] out_byte;
    logic       out_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_data, m_rin, m_ctrl;
    logic       m_b7, m_ack, m_tmo, m_pend;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_NS/2) clk = ~clk;

    prn_port_ctrl u_prn_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rev_load(rev_load), .rev_data(rev_data), .irq(irq),
        .out_byte(out_byte), .out_valid(out_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_b7, m_ack, 1'b0, 1'b1, 1'b1, 2'b00, m_tmo};
    endfunction

    task automatic model_reset();
        m_data = 8'hFF; m_rin = 8'hFF; m_ctrl = 8'hCC;
        m_b7 = 1'b1; m_ack = 1'b1; m_tmo = 1'b1; m_pend = 1'b0;
    endtask

    // Model of a write; returns whether a byte is emitted and which one.
    task automatic model_wr(input logic [2:0] a, input logic [7:0] d,
                            output logic emit, output logic [7:0] eb);
        logic [7:0] v;
        emit = 1'b0; eb = m_data;
        if (a == 3'd0) m_data = d;
        else if (a == 3'd2) begin
            v = d | 8'hC0;
            if (!v[2]) begin m_b7 = 1'b1; m_ack = 1'b1; m_tmo = 1'b0; end
            else if (v[3]) begin
                if (v[0]) begin m_b7 = 1'b0; emit = !m_ctrl[0]; end
                else if (m_ctrl[4]) m_pend = 1'b1;
            end
            m_ctrl = v;
        end
    endtask

    task automatic model_rd(input logic [2:0] a, output logic [7:0] r);
        r = 8'hFF;
        if (a == 3'd0) r = m_ctrl[5] ? m_rin : m_data;
        else if (a == 3'd2) r = m_ctrl;
        else if (a == 3'd1) begin
            r = m_status();
            m_pend = 1'b0;
            if (!m_b7 && !m_ctrl[0]) begin
                if (m_ack) m_ack = 1'b0;
                else begin m_ack = 1'b1; m_b7 = 1'b1; end
            end
        end
    endtask

    task automatic op_wr(input logic [2:0] a, input logic [7:0] d);
        logic emit; logic [7:0] eb;
        model_wr(a, d, emit, eb);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        chk("R5 out_valid", {7'd0, out_valid}, {7'd0, emit});
        if (emit) chk("R5 out_byte", out_byte, eb);
        chk("R6 irq", {7'd0, irq}, {7'd0, m_pend});
        if (emit) begin
            @(posedge clk); #1;
            chk("R5 pulse width", {7'd0, out_valid}, 8'd0);
        end
    endtask

    task automatic op_rd(input logic [2:0] a, input string req);
        logic [7:0] r;
        model_rd(a, r);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk(req, bus_rdata, r);
        chk("R7 irq after read", {7'd0, irq}, {7'd0, m_pend});
    endtask

    task automatic op_both(input logic [2:0] a, input logic [7:0] d);
        logic emit; logic [7:0] eb; logic [7:0] prev;
        prev = bus_rdata;
        model_wr(a, d, emit, eb);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R11 rdata held", bus_rdata, prev);
        chk("R11 irq kept", {7'd0, irq}, {7'd0, m_pend});
    endtask

    task automatic load_rev(input logic [7:0] d);
        @(negedge clk);
        rev_load = 1'b1; rev_data = d;
        @(posedge clk); #1;
        rev_load = 1'b0;
        m_rin = d;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
        op_rd(3'd2, "R1 control");
        op_rd(3'd1, "R1 status");
        op_rd(3'd0, "R1 data");

        // R2 bad offsets read 0xFF, writes there change nothing
        for (int a = 3; a < 8; a++) begin
            op_wr(3'(a), 8'h00);
            op_rd(3'(a), "R2 bad offset");
        end
        op_wr(3'd1, 8'h00);
        op_rd(3'd1, "R2 status write ignored");
        op_rd(3'd2, "R2 control untouched");

        // R5 and R8 handshake sequence
        op_wr(3'd0, 8'h5A);
        op_wr(3'd2, 8'h0C);
        op_wr(3'd2, 8'h0D);
        op_wr(3'd2, 8'h0D);
        op_rd(3'd1, "R8 busy strobe high");
        op_rd(3'd1, "R8 no step strobe high");
        op_wr(3'd2, 8'h0C);
        op_rd(3'd1, "R8 step ack drop");
        op_rd(3'd1, "R8 step ack return");
        op_rd(3'd1, "R8 ready");
        op_wr(3'd2, 8'h05);
        op_rd(3'd1, "R5 select low no busy");

        // R4 initialize
        op_wr(3'd2, 8'h0D);
        op_wr(3'd2, 8'h08);
        op_rd(3'd1, "R4 init status");

        // R6 and R7 interrupt
        op_wr(3'd2, 8'h1C);
        op_wr(3'd2, 8'h1C);
        chk("R6 irq set", {7'd0, irq}, 8'd1);
        op_both(3'd1, 8'h00);
        op_rd(3'd1, "R7 status read clears");
        chk("R7 irq low", {7'd0, irq}, 8'd0);

        // R9 direction select
        load_rev(8'hA5);
        op_wr(3'd2, 8'h2C);
        op_rd(3'd0, "R9 input latch");
        op_wr(3'd2, 8'h0C);
        op_rd(3'd0, "R9 output latch");

        // R3 sweep all control bytes, R10 readback per access
        for (int v = 0; v < 256; v++) begin
            op_wr(3'd2, 8'(v));
            op_rd(3'd2, "R3 control readback");
            op_rd(3'd1, "R10 status after write");
        end

        // Mixed pseudo-random stream against the model
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            unique case (lfsr[2:0])
                3'd0, 3'd1: op_wr(3'd2, lfsr[15:8] | (lfsr[3] ? 8'h04 : 8'h00));
                3'd2: op_wr(3'd0, lfsr[15:8]);
                3'd3, 3'd4: op_rd(3'd1, "R8 stream status");
                3'd5: op_rd({1'b0, lfsr[4], 1'b0}, "R9 stream data/control");
                3'd6: op_rd(lfsr[7:5], "R2 stream any offset");
                3'd7: begin load_rev(lfsr[15:8]); op_rd(3'd0, "R9 stream reverse"); end
                default: ;
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule